// File: doc/BRIEF.md
# I2C Serial Memory Target Front End

This block is the bus-facing half of a serial memory that answers as an I2C target. It samples the raw clock and data lines in the system clock domain. Each line goes through a two-flop synchronizer and then a stability counter that rejects short pulses. From the cleaned lines it derives clock edges and START/STOP conditions, collects the address byte, and compares it with a fixed 4-bit device type code and three strap inputs. It then moves data bytes in either direction, including the acknowledge on the ninth clock.

A memory command sequencer sits behind the block and talks to it through single-cycle strobes. The block reports START, STOP, an accepted address together with its direction bit, each received byte, each master acknowledge, and each request for the next byte to transmit. The sequencer can veto the acknowledge in two places. It raises `busy_i` while an internal write is running. It drops `ack_en_i` when data must be refused, for example because the array is write-protected. The data line is handled as open drain: the block reports only whether it pulls the line low.

Top module: `i2c_mem_target`

## Requirements
- R1: A falling SDA while SCL stays high gives exactly one `start_o` pulse. A rising SDA while SCL stays high gives exactly one `stop_o` pulse. No address is collected until a START has been seen.
- R2: The byte after a START is compared as an address. Bits [7:4] must be 4'b1010 and bits [3:1] must equal `strap_i[2:0]`. On a match with `busy_i` low, the block pulses `addr_hit_o` and pulls SDA low for the whole ninth clock. Otherwise it leaves SDA released.
- R3: `busy_i` is sampled at the SCL falling edge that ends the eighth address bit. If it is high, the address is not acknowledged, no `addr_hit_o` pulse appears, and every later byte is ignored (no acknowledge, no `rx_valid_o`) until the next START.
- R4: When address bit 0 is 0 (write), each following byte is taken MSB first on SCL rising edges. It is presented on `rx_byte_o` with a one-cycle `rx_valid_o` at its eighth rising edge. The byte is acknowledged only if `ack_en_i` is high at the next falling edge. A refused byte leaves the block idle until the next START.
- R5: When address bit 0 is 1 (read), `tx_req_o` pulses together with `addr_hit_o` and after each master acknowledge. `tx_byte_i` is loaded at the SCL falling edge that ends the ninth clock and is shifted out MSB first. Each bit changes only after an SCL falling edge.
- R6: In read mode the block releases SDA during the ninth clock. It pulses `mack_valid_o` with `mnack_o` equal to the sampled SDA (1 = NACK). After a NACK no further `tx_req_o` appears and SDA stays released.
- R7: SDA is only ever pulled low (`sda_pull_o` = 1) or released (`sda_pull_o` = 0). It is released after reset and whenever the block is idle.
- R8: A pulse on SCL or SDA shorter than `FILT_CYC` system clocks has no effect: it adds no bit and creates no START or STOP.
- R9: A START seen in any state, including after an acknowledged write address, restarts address collection. This allows a write-address-then-read sequence.
- R10: A STOP seen in any state, including in the middle of a byte, returns the block to idle with SDA released and pulses `stop_o`.
- R11: While reset is held, all strobes and `sda_pull_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock level |
| sda_i | input | 1 | Raw bus data level (wired-AND of all drivers) |
| sda_pull_o | output | 1 | 1 = pull SDA low, 0 = release |
| strap_i | input | 3 | Pin-selected low address bits |
| busy_i | input | 1 | Sequencer busy; withholds the address acknowledge |
| ack_en_i | input | 1 | Permits acknowledge of a received data byte |
| tx_byte_i | input | 8 | Next byte to transmit in read mode |
| start_o | output | 1 | START strobe |
| stop_o | output | 1 | STOP strobe |
| addr_hit_o | output | 1 | Address accepted strobe |
| rw_o | output | 1 | Direction of the last accepted address (1 = read) |
| rx_valid_o | output | 1 | Received byte strobe |
| rx_byte_o | output | 8 | Last received byte |
| tx_req_o | output | 1 | Request for the next transmit byte |
| mack_valid_o | output | 1 | Master acknowledge sampled strobe |
| mnack_o | output | 1 | Last master acknowledge value (1 = NACK) |

## Verification
Two events share one clock cycle. The SCL rising edge of the master's acknowledge slot produces `mack_valid_o`, and on an ACK the same edge also produces the `tx_req_o` for the following byte. A sequential read in which the master acknowledges four bytes and refuses the fifth provokes this. The bench counts requests against acknowledges: five requests, one of them tied to the address. It compares each shifted byte with the arithmetic pattern the bench sequencer supplies, so a lost or doubled request shows up as wrong data. A second coincidence is a START that arrives while the block is still holding an acknowledged write address. The repeated-START read checks that the new address wins.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int BYTE_W  = 8;
    localparam int STRAP_W = 3;
    localparam int TYPE_W  = BYTE_W - 1 - STRAP_W;
    localparam int BCNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_RX,
        ST_RACK,
        ST_TX,
        ST_TACK
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e          st;
        logic [BYTE_W-1:0]   sh;
        logic [BCNT_W-1:0]   cnt;
        logic                rw;
        logic                pull;
        logic [BYTE_W-1:0]   rxb;
        logic                mnack;
        logic                start_p;
        logic                stop_p;
        logic                hit_p;
        logic                rxv_p;
        logic                txr_p;
        logic                mackv_p;
    } eng_t;
endpackage

// File: rtl/i2c_tgt_glitch.sv
module i2c_tgt_glitch #(
    parameter int FILT_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic          s1_q, s2_q, out_q, out_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        out_d = out_q;
        cnt_d = '0;
        if (s2_q != out_q) begin
            if (cnt_q == LAST) begin
                out_d = s2_q;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q  <= 1'b1;
            s2_q  <= 1'b1;
            out_q <= 1'b1;
            cnt_q <= '0;
        end else begin
            s1_q  <= line_i;
            s2_q  <= s1_q;
            out_q <= out_d;
            cnt_q <= cnt_d;
        end
    end

    assign line_o = out_q;
endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
        start_det = scl_f & scl_q & sda_q & ~sda_f;
        stop_det  = scl_f & scl_q & ~sda_q & sda_f;
    end
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [TYPE_W-1:0] TYPE_CODE = 4'b1010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               sda_s,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               busy_i,
    input  logic               ack_en_i,
    input  logic [BYTE_W-1:0]  tx_byte_i,
    output eng_t               eng_o
);
    localparam logic [BCNT_W-1:0] CNT_FULL = BCNT_W'(BYTE_W);
    localparam logic [BCNT_W-1:0] CNT_LAST = BCNT_W'(BYTE_W - 1);

    eng_t q, d;
    logic addr_match;

    assign addr_match = (q.sh[BYTE_W-1 -: TYPE_W] == TYPE_CODE) &&
                        (q.sh[STRAP_W:1] == strap_i);

    always_comb begin
        d         = q;
        d.start_p = 1'b0;
        d.stop_p  = 1'b0;
        d.hit_p   = 1'b0;
        d.rxv_p   = 1'b0;
        d.txr_p   = 1'b0;
        d.mackv_p = 1'b0;
        if (stop_det) begin
            d.st     = ST_IDLE;
            d.pull   = 1'b0;
            d.stop_p = 1'b1;
        end else if (start_det) begin
            d.st      = ST_ADDR;
            d.cnt     = '0;
            d.pull    = 1'b0;
            d.start_p = 1'b1;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == CNT_FULL) begin
                        if (addr_match && !busy_i) begin
                            d.st    = ST_AACK;
                            d.pull  = 1'b1;
                            d.rw    = q.sh[0];
                            d.hit_p = 1'b1;
                            d.txr_p = q.sh[0];
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.st   = ST_TX;
                            d.sh   = tx_byte_i;
                            d.pull = ~tx_byte_i[BYTE_W-1];
                        end else begin
                            d.st   = ST_RX;
                            d.pull = 1'b0;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == CNT_LAST) begin
                            d.rxb   = {q.sh[BYTE_W-2:0], sda_s};
                            d.rxv_p = 1'b1;
                        end
                    end else if (scl_fall && q.cnt == CNT_FULL) begin
                        if (ack_en_i) begin
                            d.st   = ST_RACK;
                            d.pull = 1'b1;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_fall) begin
                        d.st   = ST_RX;
                        d.cnt  = '0;
                        d.pull = 1'b0;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == CNT_LAST) begin
                            d.st   = ST_TACK;
                            d.pull = 1'b0;
                        end else begin
                            d.sh   = {q.sh[BYTE_W-2:0], 1'b0};
                            d.pull = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_TACK: begin
                    if (scl_rise) begin
                        d.mackv_p = 1'b1;
                        d.mnack   = sda_s;
                        d.txr_p   = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mnack) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.st   = ST_TX;
                            d.cnt  = '0;
                            d.sh   = tx_byte_i;
                            d.pull = ~tx_byte_i[BYTE_W-1];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign eng_o = q;
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2c_tgt_pkg::*;
#(
    parameter int                FILT_CYC  = 10,
    parameter logic [TYPE_W-1:0] TYPE_CODE = 4'b1010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               busy_i,
    input  logic               ack_en_i,
    input  logic [BYTE_W-1:0]  tx_byte_i,
    output logic               start_o,
    output logic               stop_o,
    output logic               addr_hit_o,
    output logic               rw_o,
    output logic               rx_valid_o,
    output logic [BYTE_W-1:0]  rx_byte_o,
    output logic               tx_req_o,
    output logic               mack_valid_o,
    output logic               mnack_o
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines, filt_lines;
    logic scl_rise, scl_fall, start_det, stop_det;
    eng_t eng;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_filt
        i2c_tgt_glitch #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (filt_lines[g])
        );
    end

    i2c_tgt_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (filt_lines[1]),
        .sda_f     (filt_lines[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_engine #(.TYPE_CODE(TYPE_CODE)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_s     (filt_lines[0]),
        .strap_i   (strap_i),
        .busy_i    (busy_i),
        .ack_en_i  (ack_en_i),
        .tx_byte_i (tx_byte_i),
        .eng_o     (eng)
    );

    assign sda_pull_o   = eng.pull;
    assign start_o      = eng.start_p;
    assign stop_o       = eng.stop_p;
    assign addr_hit_o   = eng.hit_p;
    assign rw_o         = eng.rw;
    assign rx_valid_o   = eng.rxv_p;
    assign rx_byte_o    = eng.rxb;
    assign tx_req_o     = eng.txr_p;
    assign mack_valid_o = eng.mackv_p;
    assign mnack_o      = eng.mnack;
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk (
    input logic clk,
    input logic rst_n,
    input logic sda_pull_o,
    input logic busy_i,
    input logic start_o,
    input logic stop_o,
    input logic addr_hit_o,
    input logic rw_o,
    input logic rx_valid_o,
    input logic tx_req_o,
    input logic mack_valid_o,
    input logic mnack_o
);
    assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_o, stop_o, addr_hit_o, rx_valid_o, mack_valid_o}));

    assert_hit_pulls_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit_o |-> sda_pull_o);

    assert_busy_veto_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit_o |-> !$past(busy_i));

    assert_rx_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> !sda_pull_o);

    assert_read_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit_o |-> (tx_req_o == rw_o));

    assert_mack_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mack_valid_o |-> !sda_pull_o);

    assert_req_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req_o && !addr_hit_o) |-> (mack_valid_o && !mnack_o));

    assert_start_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !sda_pull_o);

    assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !sda_pull_o);
endmodule

bind i2c_mem_target i2c_mem_target_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sda_pull_o   (sda_pull_o),
    .busy_i       (busy_i),
    .start_o      (start_o),
    .stop_o       (stop_o),
    .addr_hit_o   (addr_hit_o),
    .rw_o         (rw_o),
    .rx_valid_o   (rx_valid_o),
    .tx_req_o     (tx_req_o),
    .mack_valid_o (mack_valid_o),
    .mnack_o      (mnack_o)
);

// File: tb/test_i2c_mem_target.sv
`timescale 1ns/1ps
module test_i2c_mem_target;
    localparam int FILT = 10;
    localparam int Q    = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_pull;
    logic [2:0] strap = 3'd0;
    logic       busy = 1'b0, ack_en = 1'b1;
    logic [7:0] tx_byte = 8'h00;
    logic       start_s, stop_s, hit_s, rw_s, rxv_s, txr_s, mackv_s, mnack_s;
    logic [7:0] rx_byte;
    wire        sda_bus = sda_m & ~sda_pull;

    int n_vec = 0, n_err = 0;
    int c_start = 0, c_stop = 0, c_hit = 0, c_rxv = 0, c_txr = 0, c_mack = 0;
    int tx_idx = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    i2c_mem_target #(.FILT_CYC(FILT)) i_i2c_mem_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_pull_o(sda_pull), .strap_i(strap), .busy_i(busy),
        .ack_en_i(ack_en), .tx_byte_i(tx_byte), .start_o(start_s),
        .stop_o(stop_s), .addr_hit_o(hit_s), .rw_o(rw_s),
        .rx_valid_o(rxv_s), .rx_byte_o(rx_byte), .tx_req_o(txr_s),
        .mack_valid_o(mackv_s), .mnack_o(mnack_s)
    );

    function automatic logic [7:0] rd_exp(int k);
        return 8'((k * 37) ^ 8'h3C);
    endfunction

    always @(posedge clk) begin
        if (start_s) c_start++;
        if (stop_s)  c_stop++;
        if (hit_s)   c_hit++;
        if (rxv_s)   c_rxv++;
        if (mackv_s) c_mack++;
        if (txr_s) begin
            c_txr++;
            tx_byte <= rd_exp(tx_idx);
            tx_idx  <= tx_idx + 1;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic bit_w(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bit_r(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_bus;  tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    // short pulses on both lines inside one data bit
    task automatic bit_g(input logic b);
        sda_m = b; tick(Q / 2);
        scl_m = 1'b1; tick(FILT - 1); scl_m = 1'b0;
        tick(Q - Q / 2 - (FILT - 1));
        scl_m = 1'b1; tick(8);
        sda_m = ~b; tick(FILT - 1); sda_m = b;
        tick(2 * Q - 8 - (FILT - 1));
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] v, input bit glitch, output bit ack);
        logic a;
        for (int i = 7; i >= 0; i--) begin
            if (glitch) bit_g(v[i]); else bit_w(v[i]);
        end
        bit_r(a);
        ack = ~a;
    endtask

    task automatic rd_byte(output logic [7:0] v, input bit mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_r(b);
            v[i] = b;
        end
        bit_w(~mack);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_vec++; n_err++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        bit ack;
        logic [7:0] v;
        int s0, p0, h0, r0, q0, m0, k0;

        tick(4);
        // R11 reset state
        check("R11 pull in reset", sda_pull, 0);
        check("R11 strobes in reset",
              {start_s, stop_s, hit_s, rxv_s, txr_s, mackv_s}, 0);
        rst_n = 1'b1;
        tick(30);
        check("R7 released after reset", sda_pull, 0);

        // R2 / R1: sweep straps against all pin-bit values and two wrong codes
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            for (int a = 0; a < 10; a++) begin
                logic [3:0] code = (a < 8) ? 4'hA : ((a == 8) ? 4'hB : 4'h2);
                logic [2:0] pins = (a < 8) ? 3'(a) : 3'(s);
                s0 = c_start; p0 = c_stop; h0 = c_hit;
                bus_start();
                wr_byte({code, pins, 1'b0}, 0, ack);
                bus_stop();
                check("R2 address ack", ack, (code == 4'hA && pins == 3'(s)));
                check("R2 addr_hit count", c_hit - h0,
                      (code == 4'hA && pins == 3'(s)) ? 1 : 0);
                check("R1 start count", c_start - s0, 1);
                check("R1 stop count", c_stop - p0, 1);
            end
        end
        strap = 3'd5;

        // R4: write stream, then refusal leaves the block idle
        r0 = c_rxv;
        bus_start();
        wr_byte({4'hA, 3'd5, 1'b0}, 0, ack);
        check("R4 write addr ack", ack, 1);
        check("R4 rw_o write", rw_s, 0);
        for (int i = 0; i < 4; i++) begin
            wr_byte(8'(8'h5A + 8'(i * 29)), 0, ack);
            check("R4 data ack", ack, 1);
            check("R4 rx byte", rx_byte, 8'(8'h5A + 8'(i * 29)));
        end
        ack_en = 1'b0;
        wr_byte(8'hC3, 0, ack);
        check("R4 refused byte nack", ack, 0);
        check("R4 refused byte seen", rx_byte, 8'hC3);
        ack_en = 1'b1;
        wr_byte(8'h11, 0, ack);
        check("R4 idle after refusal no ack", ack, 0);
        check("R4 rx_valid count", c_rxv - r0, 5);
        bus_stop();

        // R3: busy withholds address ack and later bytes are ignored
        busy = 1'b1;
        h0 = c_hit; r0 = c_rxv;
        bus_start();
        wr_byte({4'hA, 3'd5, 1'b0}, 0, ack);
        busy = 1'b0;
        check("R3 busy address nack", ack, 0);
        wr_byte(8'h77, 0, ack);
        check("R3 ignored byte nack", ack, 0);
        check("R3 no rx_valid", c_rxv - r0, 0);
        check("R3 no addr_hit", c_hit - h0, 0);
        check("R3 released", sda_pull, 0);
        bus_stop();
        bus_start();
        wr_byte({4'hA, 3'd5, 1'b0}, 0, ack);
        check("R3 next START accepted", ack, 1);
        bus_stop();

        // R5 / R6: sequential read, four ACKs then NACK
        q0 = c_txr; m0 = c_mack;
        bus_start();
        k0 = tx_idx;
        wr_byte({4'hA, 3'd5, 1'b1}, 0, ack);
        check("R5 read addr ack", ack, 1);
        check("R5 rw_o read", rw_s, 1);
        for (int i = 0; i < 5; i++) begin
            rd_byte(v, i < 4);
            check("R5 read data", v, rd_exp(k0 + i));
        end
        check("R6 tx_req count", c_txr - q0, 5);
        check("R6 mack count", c_mack - m0, 5);
        check("R6 final nack flag", mnack_s, 1);
        check("R6 released after nack", sda_pull, 0);
        bus_stop();

        // R9: write address then repeated START into read
        s0 = c_start; h0 = c_hit; p0 = c_stop;
        bus_start();
        wr_byte({4'hA, 3'd5, 1'b0}, 0, ack);
        check("R9 first addr ack", ack, 1);
        wr_byte(8'h12, 0, ack);
        check("R9 word byte", rx_byte, 8'h12);
        k0 = tx_idx;
        bus_start();
        wr_byte({4'hA, 3'd5, 1'b1}, 0, ack);
        check("R9 restart addr ack", ack, 1);
        rd_byte(v, 0);
        check("R9 read after restart", v, rd_exp(k0));
        bus_stop();
        check("R9 start count", c_start - s0, 2);
        check("R9 hit count", c_hit - h0, 2);
        check("R10 single stop", c_stop - p0, 1);

        // R10: STOP in the middle of a byte
        p0 = c_stop;
        bus_start();
        wr_byte({4'hA, 3'd5, 1'b0}, 0, ack);
        bit_w(1'b1); bit_w(1'b0); bit_w(1'b1);
        bus_stop();
        check("R10 stop mid byte", c_stop - p0, 1);
        check("R10 released", sda_pull, 0);
        bus_start();
        wr_byte({4'hA, 3'd5, 1'b0}, 0, ack);
        check("R10 fresh transaction", ack, 1);
        bus_stop();

        // R8: short pulses on both lines during a data byte
        s0 = c_start; p0 = c_stop; r0 = c_rxv;
        bus_start();
        wr_byte({4'hA, 3'd5, 1'b0}, 0, ack);
        wr_byte(8'hA5, 1, ack);
        check("R8 glitched byte ack", ack, 1);
        check("R8 glitched byte value", rx_byte, 8'hA5);
        check("R8 no extra start", c_start - s0, 1);
        check("R8 no false stop", c_stop - p0, 0);
        check("R8 one byte", c_rxv - r0, 1);
        bus_stop();

        tick(10);
        finish_run();
    end
endmodule